// File: doc/BRIEF.md
# Per-Processor Local Register Window

This block keeps one small bank of local state per processor: a control word, a compare-pending bit, a local enable mask, a compare routing map and an indirection pointer. It also answers identity and compare-value reads. Every request carries the index of the processor that issues it. A window select bit picks one of two views. The direct view reaches the requester's own bank. The indirect view reaches the bank named by the requester's pointer register, which lets one processor set up another processor's local state.

The compare value itself lives in a separate counter block. Compare-low writes are forwarded to that block one cycle later, together with the target bank index. Compare-low reads return the counter block's value for the target bank. The block drives each bank's compare pending bit, compare enable bit and routing map toward an interrupt router.

Requests take one cycle with no handshake. Read data is registered and appears one cycle after the request.

Top module: `pcpu_local_regs`

## Requirements
- R1: With `req_other`=0, an access targets the bank of `req_cpu`, and no other bank changes.
- R2: With `req_other`=1, an access targets the bank whose index is held in the requester's pointer register (offset 6).
- R3: A write to the pointer register (offset 6) is stored only when the whole 32-bit write value is below NUM_CPU. Otherwise the register keeps its value.
- R4: The identity register (offset 7) reads back the target bank index. Compare-high (offset 9) always reads 0.
- R5: Writes to the control register (offset 0) have no effect, and it always reads 0.
- R6: The mask (read at offset 2) covers bits 5:0 only. A write to offset 4 ORs in data bits 5:0. A write to offset 3 clears the bits that are set in data bits 5:0. Higher data bits are ignored.
- R7: A compare-map write (offset 5) is rejected, leaving the map unchanged, when data bits 5:0 exceed MAX_PIN (5). An accepted write stores the pin in bits 5:0 and the routing flag in bit 31, and reads back with all other bits zero.
- R8: After reset, every bank reads control 0, pending 0, mask 0x32, map 0x8000_0000 and pointer 0.
- R9: A compare-low write (offset 8) clears the target's pending bit 1 (offset 1). One cycle later it raises `cmp_wr_valid` for one cycle, with the target index and the write data. A `timer_expire` pulse sets pending bit 1, and it wins over a same-cycle clear. A compare-low read returns that bank's slice of `cmp_value_in`.
- R10: Offsets 10 to 15 read 0, and writes to them change nothing.
- R11: For each bank i: `cmp_pending[i]` is pending bit 1, `cmp_enabled[i]` is mask bit 1, `cmp_pin` slice i is map bits 5:0, and `cmp_pin_en[i]` is map bit 31.
- R12: `rd_data` carries the read result in the cycle after a read request, and is 0 after any cycle without a read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_other | input | 1 | 0 = own bank, 1 = bank named by the pointer |
| req_cpu | input | CPU_W | Index of the requesting processor |
| req_off | input | 4 | Register offset |
| req_wdata | input | 32 | Write data |
| rd_data | output | 32 | Registered read data |
| cmp_value_in | input | 32*NUM_CPU | Compare values from the counter block, bank i at slice i |
| timer_expire | input | NUM_CPU | Compare match pulses, one per bank |
| cmp_wr_valid | output | 1 | Forwarded compare-low write strobe |
| cmp_wr_cpu | output | CPU_W | Bank index of the forwarded write |
| cmp_wr_data | output | 32 | Data of the forwarded write |
| cmp_pending | output | NUM_CPU | Compare pending, per bank |
| cmp_enabled | output | NUM_CPU | Compare enable (mask bit 1), per bank |
| cmp_pin | output | PIN_W*NUM_CPU | Compare routing pin, per bank |
| cmp_pin_en | output | NUM_CPU | Compare routing flag, per bank |

## Verification
Every bank register and every routed output is updated at the clock edge that samples the request, so the change shows up in the following cycle. Read data and the forwarded compare write are due exactly one edge after their request. The bench's reference model advances at each rising edge from the same inputs, and its result is compared one nanosecond after that edge. The directed tasks drive on a falling edge and sample on the next falling edge, which falls inside the cycle where each result is due.

// File: rtl/lrw_pkg.sv
package lrw_pkg;
  localparam int DW    = 32;
  localparam int OFF_W = 4;
  localparam int FLAG_BIT = 31;

  localparam logic [OFF_W-1:0] OFF_CTRL     = 4'd0;
  localparam logic [OFF_W-1:0] OFF_PEND     = 4'd1;
  localparam logic [OFF_W-1:0] OFF_MASK     = 4'd2;
  localparam logic [OFF_W-1:0] OFF_MASK_CLR = 4'd3;
  localparam logic [OFF_W-1:0] OFF_MASK_SET = 4'd4;
  localparam logic [OFF_W-1:0] OFF_CMAP     = 4'd5;
  localparam logic [OFF_W-1:0] OFF_OTHER    = 4'd6;
  localparam logic [OFF_W-1:0] OFF_IDENT    = 4'd7;
  localparam logic [OFF_W-1:0] OFF_CMP_LO   = 4'd8;
  localparam logic [OFF_W-1:0] OFF_CMP_HI   = 4'd9;

  // Low-bit field mask of a given width.
  function automatic logic [DW-1:0] field_mask(int width);
    return (DW'(1) << width) - DW'(1);
  endfunction

  // Mask update from the set and clear strobes.
  function automatic logic [DW-1:0] mask_update(logic [DW-1:0] cur, logic [DW-1:0] wd,
                                                 logic set, logic clr, int width);
    logic [DW-1:0] f;
    f = wd & field_mask(width);
    if (set)      return cur | f;
    else if (clr) return cur & ~f;
    return cur;
  endfunction

  // Pin field of a map write is legal if it is at most max_pin.
  function automatic logic pin_legal(logic [DW-1:0] wd, int width, int max_pin);
    return (wd & field_mask(width)) <= DW'(max_pin);
  endfunction

  function automatic logic index_legal(logic [DW-1:0] wd, int count);
    return wd < DW'(count);
  endfunction

  function automatic logic [DW-1:0] bit_word(logic b, int pos);
    return DW'(b) << pos;
  endfunction

  function automatic logic [DW-1:0] map_word(logic flag, logic [DW-1:0] pin);
    return bit_word(flag, FLAG_BIT) | pin;
  endfunction
endpackage

// File: rtl/lrw_target_sel.sv
module lrw_target_sel #(
  parameter int NUM_CPU = 4,
  parameter int CPU_W   = 2
) (
  input  logic                     req_other,
  input  logic [CPU_W-1:0]         req_cpu,
  input  logic [NUM_CPU*CPU_W-1:0] other_flat,
  output logic [CPU_W-1:0]         tgt_idx,
  output logic                     tgt_ok
);
  localparam logic [CPU_W:0] NCPU_V = (CPU_W+1)'(NUM_CPU);

  logic             cpu_ok;
  logic [CPU_W-1:0] base_cpu;

  assign cpu_ok   = {1'b0, req_cpu} < NCPU_V;
  assign base_cpu = cpu_ok ? req_cpu : '0;
  assign tgt_idx  = req_other ? other_flat[base_cpu*CPU_W +: CPU_W] : base_cpu;
  assign tgt_ok   = cpu_ok;
endmodule

// File: rtl/lrw_bank.sv
module lrw_bank import lrw_pkg::*; #(
  parameter int NUM_CPU  = 4,
  parameter int CPU_W    = 2,
  parameter int MASK_W   = 6,
  parameter int MASK_RST = 'h32,
  parameter int PIN_W    = 6,
  parameter int MAX_PIN  = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [OFF_W-1:0]  wr_off,
  input  logic [DW-1:0]     wr_data,
  input  logic              expire,
  output logic [MASK_W-1:0] mask_q,
  output logic              pend_cmp_q,
  output logic [PIN_W-1:0]  map_pin_q,
  output logic              map_en_q,
  output logic [CPU_W-1:0]  other_q
);
  localparam logic [MASK_W-1:0] MRST   = MASK_W'(MASK_RST);
  localparam logic [PIN_W-1:0]  MAXP   = PIN_W'(MAX_PIN);
  localparam logic [CPU_W:0]    NCPU_V = (CPU_W+1)'(NUM_CPU);

  // Named write events.
  logic wr_mask_set, wr_mask_clr, wr_map_ok, wr_map_bad;
  logic wr_other_ok, wr_other_bad, wr_cmp_lo;
  logic [DW-1:0] mask_nx;

  assign wr_mask_set  = wr_en && (wr_off == OFF_MASK_SET);
  assign wr_mask_clr  = wr_en && (wr_off == OFF_MASK_CLR);
  assign wr_map_ok    = wr_en && (wr_off == OFF_CMAP) &&  pin_legal(wr_data, PIN_W, MAX_PIN);
  assign wr_map_bad   = wr_en && (wr_off == OFF_CMAP) && !pin_legal(wr_data, PIN_W, MAX_PIN);
  assign wr_other_ok  = wr_en && (wr_off == OFF_OTHER) &&  index_legal(wr_data, NUM_CPU);
  assign wr_other_bad = wr_en && (wr_off == OFF_OTHER) && !index_legal(wr_data, NUM_CPU);
  assign wr_cmp_lo    = wr_en && (wr_off == OFF_CMP_LO);
  assign mask_nx      = mask_update(DW'(mask_q), wr_data, wr_mask_set, wr_mask_clr, MASK_W);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mask_q     <= MRST;
      pend_cmp_q <= 1'b0;
      map_pin_q  <= '0;
      map_en_q   <= 1'b1;
      other_q    <= '0;
    end else begin
      mask_q <= mask_nx[MASK_W-1:0];
      if (expire)         pend_cmp_q <= 1'b1;
      else if (wr_cmp_lo) pend_cmp_q <= 1'b0;
      if (wr_map_ok) begin
        map_pin_q <= wr_data[PIN_W-1:0];
        map_en_q  <= wr_data[FLAG_BIT];
      end
      if (wr_other_ok) other_q <= wr_data[CPU_W-1:0];
    end
  end

  AST_OTHER_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    {1'b0, other_q} < NCPU_V); // R3
  AST_OTHER_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    wr_other_bad |=> $stable(other_q)); // R3
  AST_MAP_PIN_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    map_pin_q <= MAXP); // R7
  AST_MAP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    wr_map_bad |=> $stable({map_en_q, map_pin_q})); // R7
  AST_PEND_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_cmp_lo && !expire) |=> !pend_cmp_q); // R9
  AST_PEND_SET: assert property (@(posedge clk) disable iff (!rst_n)
    expire |=> pend_cmp_q); // R9
  AST_MASK_SET_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
    wr_mask_set |=> ((mask_q & $past(mask_q)) == $past(mask_q))); // R6
endmodule

// File: rtl/pcpu_local_regs.sv
module pcpu_local_regs import lrw_pkg::*; #(
  parameter int NUM_CPU  = 4,
  parameter int CPU_W    = (NUM_CPU > 1) ? $clog2(NUM_CPU) : 1,
  parameter int MASK_W   = 6,
  parameter int MASK_RST = 'h32,
  parameter int CMP_BIT  = 1,
  parameter int PIN_W    = 6,
  parameter int MAX_PIN  = 5
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     req_valid,
  input  logic                     req_write,
  input  logic                     req_other,
  input  logic [CPU_W-1:0]         req_cpu,
  input  logic [OFF_W-1:0]         req_off,
  input  logic [DW-1:0]            req_wdata,
  output logic [DW-1:0]            rd_data,
  input  logic [NUM_CPU*DW-1:0]    cmp_value_in,
  input  logic [NUM_CPU-1:0]       timer_expire,
  output logic                     cmp_wr_valid,
  output logic [CPU_W-1:0]         cmp_wr_cpu,
  output logic [DW-1:0]            cmp_wr_data,
  output logic [NUM_CPU-1:0]       cmp_pending,
  output logic [NUM_CPU-1:0]       cmp_enabled,
  output logic [NUM_CPU*PIN_W-1:0] cmp_pin,
  output logic [NUM_CPU-1:0]       cmp_pin_en
);
  logic [NUM_CPU*CPU_W-1:0] other_flat;
  logic [CPU_W-1:0]         tgt_idx;
  logic                     tgt_ok;
  logic                     acc_rd, acc_wr, fwd_ev;
  logic [DW-1:0]            rd_next;

  logic [MASK_W-1:0] mask_a [NUM_CPU];
  logic [PIN_W-1:0]  pin_a  [NUM_CPU];
  logic [CPU_W-1:0]  oth_a  [NUM_CPU];
  logic [NUM_CPU-1:0] pend_v, pen_v;

  lrw_target_sel #(.NUM_CPU(NUM_CPU), .CPU_W(CPU_W)) u_sel (
    .req_other (req_other),
    .req_cpu   (req_cpu),
    .other_flat(other_flat),
    .tgt_idx   (tgt_idx),
    .tgt_ok    (tgt_ok)
  );

  assign acc_rd = req_valid && tgt_ok && !req_write;
  assign acc_wr = req_valid && tgt_ok &&  req_write;
  assign fwd_ev = acc_wr && (req_off == OFF_CMP_LO);

  for (genvar i = 0; i < NUM_CPU; i++) begin : g_bank
    logic wr_hit;
    assign wr_hit = acc_wr && (tgt_idx == CPU_W'(i));

    lrw_bank #(
      .NUM_CPU(NUM_CPU), .CPU_W(CPU_W), .MASK_W(MASK_W), .MASK_RST(MASK_RST),
      .PIN_W(PIN_W), .MAX_PIN(MAX_PIN)
    ) u_bank (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_en     (wr_hit),
      .wr_off    (req_off),
      .wr_data   (req_wdata),
      .expire    (timer_expire[i]),
      .mask_q    (mask_a[i]),
      .pend_cmp_q(pend_v[i]),
      .map_pin_q (pin_a[i]),
      .map_en_q  (pen_v[i]),
      .other_q   (oth_a[i])
    );

    assign other_flat[i*CPU_W +: CPU_W] = oth_a[i];
    assign cmp_pending[i]               = pend_v[i];
    assign cmp_enabled[i]               = mask_a[i][CMP_BIT];
    assign cmp_pin[i*PIN_W +: PIN_W]    = pin_a[i];
    assign cmp_pin_en[i]                = pen_v[i];
  end

  always_comb begin
    rd_next = '0;
    case (req_off)
      OFF_PEND:   rd_next = bit_word(pend_v[tgt_idx], CMP_BIT);
      OFF_MASK:   rd_next = DW'(mask_a[tgt_idx]);
      OFF_CMAP:   rd_next = map_word(pen_v[tgt_idx], DW'(pin_a[tgt_idx]));
      OFF_OTHER:  rd_next = DW'(oth_a[tgt_idx]);
      OFF_IDENT:  rd_next = DW'(tgt_idx);
      OFF_CMP_LO: rd_next = cmp_value_in[tgt_idx*DW +: DW];
      default:    rd_next = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_data      <= '0;
      cmp_wr_valid <= 1'b0;
      cmp_wr_cpu   <= '0;
      cmp_wr_data  <= '0;
    end else begin
      rd_data      <= acc_rd ? rd_next : '0;
      cmp_wr_valid <= fwd_ev;
      if (fwd_ev) begin
        cmp_wr_cpu  <= tgt_idx;
        cmp_wr_data <= req_wdata;
      end
    end
  end

  AST_RD_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !acc_rd |=> (rd_data == '0)); // R12
  AST_CTRL_HI_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_rd && (req_off == OFF_CTRL || req_off == OFF_CMP_HI)) |=> (rd_data == '0)); // R5
  AST_IDENT_READ: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_rd && req_off == OFF_IDENT) |=> (rd_data == DW'($past(tgt_idx)))); // R4
  AST_FWD_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    fwd_ev |=> (cmp_wr_valid && cmp_wr_data == $past(req_wdata))); // R9
  AST_FWD_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    !fwd_ev |=> !cmp_wr_valid); // R9
endmodule

// File: tb/sim_pcpu_local_regs.sv
`timescale 1ns/1ps
module sim_pcpu_local_regs;
  localparam int N = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0, req_write = 1'b0, req_other = 1'b0;
  logic [1:0]  req_cpu = '0;
  logic [3:0]  req_off = '0;
  logic [31:0] req_wdata = '0;
  logic [31:0] rd_data;
  logic [N*32-1:0] cmp_value_in;
  logic [N-1:0] timer_expire = '0;
  logic cmp_wr_valid;
  logic [1:0] cmp_wr_cpu;
  logic [31:0] cmp_wr_data;
  logic [N-1:0] cmp_pending, cmp_enabled, cmp_pin_en;
  logic [N*6-1:0] cmp_pin;

  int checks = 0, errors = 0;

  always #2.5 clk = ~clk;

  for (genvar i = 0; i < N; i++) begin : g_cv
    assign cmp_value_in[i*32 +: 32] = 32'hC0DE_0000 + 32'(i);
  end

  pcpu_local_regs u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_other(req_other), .req_cpu(req_cpu), .req_off(req_off), .req_wdata(req_wdata),
    .rd_data(rd_data), .cmp_value_in(cmp_value_in), .timer_expire(timer_expire),
    .cmp_wr_valid(cmp_wr_valid), .cmp_wr_cpu(cmp_wr_cpu), .cmp_wr_data(cmp_wr_data),
    .cmp_pending(cmp_pending), .cmp_enabled(cmp_enabled), .cmp_pin(cmp_pin),
    .cmp_pin_en(cmp_pin_en)
  );

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Behavioural reference model, advanced at every rising edge.
  logic [31:0] m_mask [N], m_pend [N], m_pin [N], m_pen [N], m_oth [N];
  logic [31:0] e_rd, e_fdata;
  logic        e_fv;
  logic [1:0]  e_fcpu;

  function automatic logic [31:0] model_read(logic [3:0] off, int t);
    case (off)
      4'd1: return m_pend[t] << 1;
      4'd2: return m_mask[t];
      4'd5: return (m_pen[t] << 31) | m_pin[t];
      4'd6: return m_oth[t];
      4'd7: return 32'(t);
      4'd8: return 32'hC0DE_0000 + 32'(t);
      default: return 32'h0;
    endcase
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < N; i++) begin
        m_mask[i] = 32'h32; m_pend[i] = 0; m_pin[i] = 0; m_pen[i] = 1; m_oth[i] = 0;
      end
      e_rd = 0; e_fv = 0; e_fcpu = 0; e_fdata = 0;
    end else begin
      int t;
      t = req_other ? int'(m_oth[req_cpu]) : int'(req_cpu);
      e_rd = (req_valid && !req_write) ? model_read(req_off, t) : 32'h0;
      e_fv = 1'b0;
      if (req_valid && req_write) begin
        case (req_off)
          4'd3: m_mask[t] = m_mask[t] & ~(req_wdata & 32'h3F);
          4'd4: m_mask[t] = m_mask[t] | (req_wdata & 32'h3F);
          4'd5: if ((req_wdata & 32'h3F) <= 5) begin
                  m_pin[t] = req_wdata & 32'h3F; m_pen[t] = 32'(req_wdata[31]);
                end
          4'd6: if (req_wdata < N) m_oth[t] = req_wdata;
          4'd8: begin
                  m_pend[t] = 0; e_fv = 1'b1; e_fcpu = 2'(t); e_fdata = req_wdata;
                end
          default: ;
        endcase
      end
      for (int i = 0; i < N; i++) if (timer_expire[i]) m_pend[i] = 1;
    end
    #1;
    chk("R12 rd_data", rd_data, e_rd);
    chk("R9 cmp_wr_valid", 32'(cmp_wr_valid), 32'(e_fv));
    chk("R9 cmp_wr_cpu", 32'(cmp_wr_cpu), 32'(e_fcpu));
    chk("R9 cmp_wr_data", cmp_wr_data, e_fdata);
    for (int i = 0; i < N; i++) begin
      chk("R9 cmp_pending", 32'(cmp_pending[i]), m_pend[i]);
      chk("R11 cmp_enabled", 32'(cmp_enabled[i]), (m_mask[i] >> 1) & 1);
      chk("R11 cmp_pin", 32'(cmp_pin[i*6 +: 6]), m_pin[i]);
      chk("R11 cmp_pin_en", 32'(cmp_pin_en[i]), m_pen[i]);
    end
  end

  task automatic wr(logic oth, int cpu, int off, logic [31:0] d);
    @(negedge clk);
    req_valid = 1; req_write = 1; req_other = oth; req_cpu = 2'(cpu);
    req_off = 4'(off); req_wdata = d;
    @(negedge clk);
    req_valid = 0; req_write = 0;
  endtask

  task automatic rd(logic oth, int cpu, int off, output logic [31:0] d);
    @(negedge clk);
    req_valid = 1; req_write = 0; req_other = oth; req_cpu = 2'(cpu); req_off = 4'(off);
    @(negedge clk);
    d = rd_data;
    req_valid = 0;
  endtask

  initial begin
    #(200000 * 5);
    errors++;
    $display("FAIL watchdog actual=running expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] d;
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R8 reset state
    rd(0, 0, 2, d); chk("R8 mask reset", d, 32'h32);
    rd(0, 3, 5, d); chk("R8 map reset", d, 32'h8000_0000);
    rd(0, 1, 6, d); chk("R8 pointer reset", d, 0);
    rd(0, 2, 1, d); chk("R8 pending reset", d, 0);
    rd(0, 0, 0, d); chk("R8 control reset", d, 0);
    // R1 own-bank write
    wr(0, 2, 4, 32'h1);
    rd(0, 2, 2, d); chk("R1 own bank mask", d, 32'h33);
    rd(0, 0, 2, d); chk("R1 other bank untouched", d, 32'h32);
    // R6 set/clear limited to field
    wr(0, 2, 3, 32'hFFFF_FF30);
    rd(0, 2, 2, d); chk("R6 clear", d, 32'h03);
    wr(0, 2, 4, 32'hFFFF_FFC0);
    rd(0, 2, 2, d); chk("R6 high bits ignored", d, 32'h03);
    // R3 pointer range
    wr(0, 0, 6, 32'd3);
    rd(0, 0, 6, d); chk("R3 pointer accept", d, 3);
    wr(0, 0, 6, 32'd4);
    rd(0, 0, 6, d); chk("R3 pointer reject 4", d, 3);
    wr(0, 0, 6, 32'hFFFF_FFFF);
    rd(0, 0, 6, d); chk("R3 pointer reject max", d, 3);
    // R2 indirect window
    wr(1, 0, 4, 32'h08);
    rd(0, 3, 2, d); chk("R2 indirect write lands in bank 3", d, 32'h3A);
    rd(0, 0, 2, d); chk("R2 requester bank untouched", d, 32'h32);
    // R4 identity and compare-high
    rd(1, 0, 7, d); chk("R4 ident indirect", d, 3);
    rd(0, 1, 7, d); chk("R4 ident own", d, 1);
    wr(0, 1, 9, 32'h55);
    rd(0, 1, 9, d); chk("R4 compare-high zero", d, 0);
    // R5 control
    wr(0, 1, 0, 32'hFFFF_FFFF);
    rd(0, 1, 0, d); chk("R5 control ignored", d, 0);
    // R7 compare map
    wr(0, 1, 5, 32'h8000_0004);
    rd(0, 1, 5, d); chk("R7 map accept", d, 32'h8000_0004);
    wr(0, 1, 5, 32'h8000_0006);
    rd(0, 1, 5, d); chk("R7 map reject pin 6", d, 32'h8000_0004);
    wr(0, 1, 5, 32'h7FFF_FF05);
    rd(0, 1, 5, d); chk("R7 map trimmed", d, 32'h0000_0005);
    chk("R11 pin out", 32'(cmp_pin[6 +: 6]), 5);
    chk("R11 pin flag out", 32'(cmp_pin_en[1]), 0);
    // R9 pending and forwarding
    @(negedge clk); timer_expire = 4'b0010;
    @(negedge clk); timer_expire = '0;
    chk("R9 pending out set", 32'(cmp_pending[1]), 1);
    rd(0, 1, 1, d); chk("R9 pending read", d, 32'h2);
    wr(0, 1, 8, 32'h1234);
    chk("R9 forward valid", 32'(cmp_wr_valid), 1);
    chk("R9 forward cpu", 32'(cmp_wr_cpu), 1);
    chk("R9 forward data", cmp_wr_data, 32'h1234);
    rd(0, 1, 1, d); chk("R9 pending cleared", d, 0);
    rd(1, 0, 8, d); chk("R9 compare read", d, 32'hC0DE_0003);
    @(negedge clk);
    req_valid = 1; req_write = 1; req_other = 0; req_cpu = 2'd2; req_off = 4'd8;
    req_wdata = 32'h77; timer_expire = 4'b0100;
    @(negedge clk);
    req_valid = 0; req_write = 0; timer_expire = '0;
    chk("R9 expire wins over clear", 32'(cmp_pending[2]), 1);
    // R10 unimplemented offsets
    wr(0, 0, 11, 32'hFFFF_FFFF);
    wr(0, 0, 15, 32'hFFFF_FFFF);
    rd(0, 0, 2, d); chk("R10 mask unchanged", d, 32'h32);
    rd(0, 0, 5, d); chk("R10 map unchanged", d, 32'h8000_0000);
    rd(0, 0, 15, d); chk("R10 read zero", d, 0);
    rd(0, 0, 10, d); chk("R10 read zero 10", d, 0);
    // R11 enable output follows mask bit 1
    chk("R11 enabled after reset", 32'(cmp_enabled[0]), 1);
    wr(0, 0, 3, 32'h2);
    chk("R11 enabled cleared", 32'(cmp_enabled[0]), 0);
    // R12 idle cycle returns zero
    rd(0, 3, 2, d);
    @(negedge clk);
    chk("R12 idle rd_data", rd_data, 0);
    repeat (3) @(negedge clk);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule